// File: doc/BRIEF.md
# Touch ADC Serial Command Front End

This block is the serial slave side of a resistive touch-panel converter. A host drives a chip select, a serial clock and a data line. The block takes in an 8-bit command byte. That byte either starts an analog conversion or reads or writes one of four small configuration registers. Conversion results go back to the host on the serial output, most significant bit first. The output can carry one result per frame, or a train of results in fixed 16-clock slots while chip select stays low.

The block runs on a fast system clock and oversamples the serial clock, chip select and data line. These inputs are assumed to be already synchronised to the system clock. The analog multiplexer and the converter sit outside the block. A request pulse carries the channel, the resolution and the power-down flag to them, and a result strobe returns a 12-bit sample. The configuration fields are presented as ports for the sequencing and panel-drive logic elsewhere on the chip.

Top module: `tsc_spi_cmd`

## Requirements
- R1: After reset, every configuration field is 0, `conv_req` and `intclk_cmd` are low, and `dout_oe` is low whenever `csn` is high.
- R2: `din` is sampled on `sclk` rising edges. A command byte (bit 7 = start, bits 6:4 = channel, bit 3 = resolution, bit 0 = power-down) with start = 1 and channel other than 010 raises one `conv_req` that carries those fields. The request is raised at rising edge 9, or at rising edge 8 when the delay flag is set.
- R3: With resolution = 0 and delay flag = 0, the 12-bit result appears on `dout` MSB first. The MSB is present after falling edge 9, the following bits after each later falling edge, and `dout` is 0 after the LSB.
- R4: With resolution = 1, only result bits 11:4 are sent, in the same window.
- R5: With the delay flag = 1, every output window starts after falling edge 8 instead of 9.
- R6: With the continuous flag = 1, result k starts 16 serial clocks after result k-1. A frame carries 6 results when the run-length flag is 0, and 10 results when it is 1. Each result has its own `conv_req`.
- R7: Channel 010 marks a setup access. Bits 3:1 give the register address and bit 0 gives the direction (0 = write). A write takes 4 data bits, MSB first, on rising edges 9–12. Register layouts (bit 3 down to bit 0) are as follows. Register 0 holds panel, continuous, run-length and delay. Register 1 holds the 3-bit sequence mode in bits 3:1. Register 2 holds the 3-bit interval in bits 3:1. Register 3 holds the 2-bit sleep field in bits 3:2 and the read-only `seq_state` in bits 1:0. Unused bits read 0.
- R8: A setup read returns the addressed register as 4 bits, MSB first, in the output window of R3/R5.
- R9: A byte whose start bit is 0 raises no request, leaves `dout` at 0 and changes no register.
- R10: Raising `csn` ends the frame. A setup write that has not reached rising edge 12 is dropped, and the next frame starts counting from edge 1.
- R11: Addresses 100–110 read back as 0 and ignore writes.
- R12: A setup byte at address 111 gives a one-cycle `intclk_cmd` pulse, with `intclk_rd` equal to the direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| csn | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for `dout` |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Requested channel |
| conv_mode | output | 1 | Requested resolution (1 = 8 bit) |
| conv_pd | output | 1 | Requested power-down flag |
| res_valid | input | 1 | Result strobe from converter |
| res_data | input | RES_W | Conversion result |
| seq_state | input | 2 | Sequencer status, read-only field |
| intclk_cmd | output | 1 | Internal-clock command pulse |
| intclk_rd | output | 1 | Direction of that command |
| cfg_panel | output | 1 | Panel type flag |
| cfg_continue | output | 1 | Continuous flag |
| cfg_count | output | 1 | Run-length flag |
| cfg_ddly | output | 1 | Early-window (delay) flag |
| cfg_seqm | output | 3 | Sequence mode |
| cfg_interval | output | 3 | Sampling interval |
| cfg_sleep | output | 2 | Sleep field |

## Verification
Conversion frames are run with different channels, both resolutions and both power-down values. This separates the 12-bit window from the truncated 8-bit one and shows whether the request fields are routed correctly. The same conversion runs with the delay flag clear and set, which exposes any one-clock error in the window position. Continuous frames run with both run lengths, so the request count and the placement of each 16-clock slot are checked against each other. Setup traffic writes values whose masked bits differ from the written ones, touches a reserved address, cuts a write short with chip select, and sends a byte without a start bit; each case is then read back through the serial interface.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned NREG   = 4;
  localparam int unsigned ADDR_W = 3;

  // command byte bit positions (decoded by the converter side as well)
  localparam int unsigned BIT_START = 7;
  localparam int unsigned BIT_MODE  = 3;
  localparam int unsigned BIT_DIR   = 0;
  localparam int unsigned BIT_PD    = 0;

  localparam logic [2:0] SETUP_CHAN  = 3'b010;
  localparam logic [2:0] INTCLK_ADDR = 3'b111;

  // edge number at which the first output slot begins
  function automatic int unsigned first_edge(input logic early, input int unsigned base);
    return early ? base - 32'd1 : base;
  endfunction

  // number of result slots in one frame
  function automatic int unsigned run_len(input logic cont, input logic long_run,
                                          input int unsigned n_short, input int unsigned n_long);
    if (!cont) return 32'd1;
    return long_run ? n_long : n_short;
  endfunction

  // true when edge n opens slot k of the frame, for some k below slots
  function automatic logic slot_hit(input int unsigned n, input int unsigned first,
                                    input int unsigned len, input int unsigned slots);
    if (n < first) return 1'b0;
    if (((n - first) % len) != 0) return 1'b0;
    return ((n - first) / len) < slots;
  endfunction
endpackage

// File: rtl/tsc_sclk_edges.sv
module tsc_sclk_edges #(
  parameter int unsigned EDGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sclk,
  output logic              rise,
  output logic              fall,
  output logic [EDGE_W-1:0] rise_n,
  output logic [EDGE_W-1:0] fall_n
);
  logic              sclk_q;
  logic [EDGE_W-1:0] rcnt, fcnt;

  assign rise   = !csn && sclk && !sclk_q;
  assign fall   = !csn && !sclk && sclk_q;
  assign rise_n = (rcnt == '1) ? rcnt : rcnt + 1'b1;
  assign fall_n = (fcnt == '1) ? fcnt : fcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      rcnt   <= '0;
      fcnt   <= '0;
    end else begin
      sclk_q <= sclk;
      if (csn) begin
        rcnt <= '0;
        fcnt <= '0;
      end else begin
        if (rise) rcnt <= rise_n;
        if (fall) fcnt <= fall_n;
      end
    end
  end
endmodule

// File: rtl/tsc_setup_regs.sv
module tsc_setup_regs
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        seq_state,
  output logic [REG_W-1:0]  rd_data,
  output logic              cfg_panel,
  output logic              cfg_continue,
  output logic              cfg_count,
  output logic              cfg_ddly,
  output logic [2:0]        cfg_seqm,
  output logic [2:0]        cfg_interval,
  output logic [1:0]        cfg_sleep
);
  localparam logic [REG_W-1:0] WMASK [NREG] = '{4'hF, 4'hE, 4'hE, 4'hC};
  localparam int unsigned STATUS_REG = NREG - 1;

  logic [REG_W-1:0] reg_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) reg_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (wr_addr == ADDR_W'(i)) reg_q[i] <= wr_data & WMASK[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = reg_q[i];
    if (rd_addr == ADDR_W'(STATUS_REG)) rd_data[1:0] = seq_state;
  end

  assign cfg_panel    = reg_q[0][3];
  assign cfg_continue = reg_q[0][2];
  assign cfg_count    = reg_q[0][1];
  assign cfg_ddly     = reg_q[0][0];
  assign cfg_seqm     = reg_q[1][3:1];
  assign cfg_interval = reg_q[2][3:1];
  assign cfg_sleep    = reg_q[3][3:2];
endmodule

// File: rtl/tsc_tx.sv
module tsc_tx #(
  parameter int unsigned RES_W = 12,
  parameter int unsigned LOW_W = 8,
  parameter int unsigned REG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csn,
  input  logic             fall,
  input  logic             load_conv,
  input  logic             load_reg,
  input  logic             low_res,
  input  logic [RES_W-1:0] res,
  input  logic [REG_W-1:0] reg_val,
  output logic             dout
);
  logic [RES_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (csn) sr <= '0;
    else if (fall) begin
      if (load_conv)
        sr <= low_res ? {res[RES_W-1 -: LOW_W], {(RES_W-LOW_W){1'b0}}} : res;
      else if (load_reg)
        sr <= {reg_val, {(RES_W-REG_W){1'b0}}};
      else
        sr <= {sr[RES_W-2:0], 1'b0};
    end
  end

  assign dout = sr[RES_W-1];
endmodule

// File: rtl/tsc_spi_cmd.sv
module tsc_spi_cmd
  import tsc_pkg::*;
#(
  parameter int unsigned RES_W     = 12,
  parameter int unsigned LOW_W     = 8,
  parameter int unsigned EDGE_W    = 8,
  parameter int unsigned SLOT_LEN  = 16,
  parameter int unsigned BASE_EDGE = 9,
  parameter int unsigned SHORT_RUN = 6,
  parameter int unsigned LONG_RUN  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csn,
  input  logic             sclk,
  input  logic             din,
  output logic             dout,
  output logic             dout_oe,
  output logic             conv_req,
  output logic [2:0]       conv_chan,
  output logic             conv_mode,
  output logic             conv_pd,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic [1:0]       seq_state,
  output logic             intclk_cmd,
  output logic             intclk_rd,
  output logic             cfg_panel,
  output logic             cfg_continue,
  output logic             cfg_count,
  output logic             cfg_ddly,
  output logic [2:0]       cfg_seqm,
  output logic [2:0]       cfg_interval,
  output logic [1:0]       cfg_sleep
);
  localparam logic [EDGE_W-1:0] BYTE_EDGE = EDGE_W'(CMD_W);
  localparam logic [EDGE_W-1:0] WR_LAST   = EDGE_W'(CMD_W + REG_W);

  logic              rise, fall;
  logic [EDGE_W-1:0] rise_n, fall_n;
  logic [CMD_W-2:0]  cmd_sr;
  logic [CMD_W-1:0]  cmd_q, cur_cmd, byte_now;
  logic              have_cmd, cur_ok, at_byte;
  logic [REG_W-2:0]  wdat_sr;
  logic [RES_W-1:0]  res_q;
  logic [REG_W-1:0]  rd_data;
  int unsigned       first, slots;

  // named internal events
  logic              conv_fire, wr_en, load_conv, load_reg, intclk_fire, q_setup, cur_setup;
  logic [ADDR_W-1:0] wr_addr;
  logic [REG_W-1:0]  wr_data;

  tsc_sclk_edges #(.EDGE_W(EDGE_W)) u_edges (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk),
    .rise(rise), .fall(fall), .rise_n(rise_n), .fall_n(fall_n)
  );

  assign byte_now  = {cmd_sr, din};
  assign at_byte   = rise && (rise_n == BYTE_EDGE);
  assign cur_cmd   = at_byte ? byte_now : cmd_q;
  assign cur_ok    = at_byte ? byte_now[BIT_START] : have_cmd;
  assign cur_setup = (cur_cmd[6:4] == SETUP_CHAN);
  assign q_setup   = (cmd_q[6:4] == SETUP_CHAN);

  assign first = first_edge(cfg_ddly, BASE_EDGE);
  assign slots = run_len(cfg_continue, cfg_count, SHORT_RUN, LONG_RUN);

  assign conv_fire = rise && cur_ok && !cur_setup &&
                     slot_hit(32'(rise_n), first, SLOT_LEN, slots);
  assign load_conv = fall && have_cmd && !q_setup &&
                     slot_hit(32'(fall_n), first, SLOT_LEN, slots);
  assign load_reg  = fall && have_cmd && q_setup && cmd_q[BIT_DIR] &&
                     (32'(fall_n) == first);

  assign wr_addr = cmd_q[3:1];
  assign wr_data = {wdat_sr, din};
  assign wr_en   = rise && (rise_n == WR_LAST) && have_cmd && q_setup &&
                   !cmd_q[BIT_DIR] && (wr_addr < ADDR_W'(NREG));

  assign intclk_fire = at_byte && byte_now[BIT_START] && (byte_now[6:4] == SETUP_CHAN) &&
                       (byte_now[3:1] == INTCLK_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_sr     <= '0;
      cmd_q      <= '0;
      have_cmd   <= 1'b0;
      wdat_sr    <= '0;
      res_q      <= '0;
      conv_req   <= 1'b0;
      conv_chan  <= '0;
      conv_mode  <= 1'b0;
      conv_pd    <= 1'b0;
      intclk_cmd <= 1'b0;
      intclk_rd  <= 1'b0;
    end else begin
      conv_req   <= conv_fire;
      intclk_cmd <= intclk_fire;
      if (intclk_fire) intclk_rd <= byte_now[BIT_DIR];
      if (conv_fire) begin
        conv_chan <= cur_cmd[6:4];
        conv_mode <= cur_cmd[BIT_MODE];
        conv_pd   <= cur_cmd[BIT_PD];
      end
      if (res_valid) res_q <= res_data;
      if (csn) begin
        cmd_sr   <= '0;
        have_cmd <= 1'b0;
        wdat_sr  <= '0;
      end else if (rise) begin
        if (rise_n < BYTE_EDGE) cmd_sr <= byte_now[CMD_W-2:0];
        if (at_byte) begin
          cmd_q    <= byte_now;
          have_cmd <= byte_now[BIT_START];
        end
        if (rise_n > BYTE_EDGE && rise_n < WR_LAST)
          wdat_sr <= {wdat_sr[REG_W-3:0], din};
      end
    end
  end

  tsc_setup_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(cmd_q[3:1]), .seq_state(seq_state), .rd_data(rd_data),
    .cfg_panel(cfg_panel), .cfg_continue(cfg_continue), .cfg_count(cfg_count),
    .cfg_ddly(cfg_ddly), .cfg_seqm(cfg_seqm), .cfg_interval(cfg_interval),
    .cfg_sleep(cfg_sleep)
  );

  tsc_tx #(.RES_W(RES_W), .LOW_W(LOW_W), .REG_W(REG_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .csn(csn), .fall(fall), .load_conv(load_conv),
    .load_reg(load_reg), .low_res(cmd_q[BIT_MODE]), .res(res_q), .reg_val(rd_data),
    .dout(dout)
  );

  assign dout_oe = !csn;
endmodule

// File: rtl/tsc_spi_cmd_chk.sv
module tsc_spi_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csn,
  input logic       dout,
  input logic       conv_req,
  input logic       have_cmd,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [3:0] cfg_bits
);
  // R1: no request while the interface has been idle
  a_r1_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn)) |-> !conv_req);

  // R6: each slot produces a single-cycle request
  a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  // R9: a request inside a frame needs an accepted start bit
  a_r9_req_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !csn) |-> have_cmd);

  // R10: configuration cannot move while chip select is high
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    csn |=> $stable(cfg_bits));

  // R10: a fresh frame starts with a quiet output
  a_r10_dout_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(csn) && !csn) |-> !dout);

  // R11: writes only reach implemented registers
  a_r11_wr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < 3'd4));
endmodule

bind tsc_spi_cmd tsc_spi_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn(csn), .dout(dout), .conv_req(conv_req),
  .have_cmd(have_cmd), .wr_en(wr_en), .wr_addr(wr_addr),
  .cfg_bits({cfg_panel, cfg_continue, cfg_count, cfg_ddly})
);

// File: tb/tb_tsc_spi_cmd.sv
module tb_tsc_spi_cmd;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;

  logic clk = 0, rst_n = 0, csn = 1, sclk = 0, din = 0;
  logic dout, dout_oe, conv_req, conv_mode, conv_pd, intclk_cmd, intclk_rd;
  logic [2:0] conv_chan, cfg_seqm, cfg_interval;
  logic [1:0] cfg_sleep, seq_state = 2'b00;
  logic cfg_panel, cfg_continue, cfg_count, cfg_ddly;
  logic res_valid = 0;
  logic [11:0] res_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsc_spi_cmd dut (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .din(din), .dout(dout),
    .dout_oe(dout_oe), .conv_req(conv_req), .conv_chan(conv_chan), .conv_mode(conv_mode),
    .conv_pd(conv_pd), .res_valid(res_valid), .res_data(res_data), .seq_state(seq_state),
    .intclk_cmd(intclk_cmd), .intclk_rd(intclk_rd), .cfg_panel(cfg_panel),
    .cfg_continue(cfg_continue), .cfg_count(cfg_count), .cfg_ddly(cfg_ddly),
    .cfg_seqm(cfg_seqm), .cfg_interval(cfg_interval), .cfg_sleep(cfg_sleep)
  );

  int n_chk = 0, n_fail = 0, nreq = 0, n_intclk = 0;
  logic last_rd = 0;
  logic [2:0] last_chan; logic last_mode, last_pd;
  logic cap [0:255];
  bit done = 0;

  function automatic logic [11:0] stub_val(input int k);
    return 12'((k * 1237 + 421) % 4096);
  endfunction

  // behavioural converter: answers each request after a short delay
  int dly = 0; logic [11:0] pend;
  always @(posedge clk) begin
    res_valid <= 1'b0;
    if (conv_req) begin
      pend <= stub_val(nreq); nreq <= nreq + 1; dly <= 3;
      last_chan <= conv_chan; last_mode <= conv_mode; last_pd <= conv_pd;
    end else if (dly > 0) begin
      dly <= dly - 1;
      if (dly == 1) begin res_valid <= 1'b1; res_data <= pend; end
    end
    if (intclk_cmd) begin n_intclk <= n_intclk + 1; last_rd <= intclk_rd; end
  end

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // scoreboard
  typedef struct { string tag; int first; int nbits; logic [11:0] val; } exp_t;
  exp_t sb [$];
  event frame_done, mon_done;

  task automatic push_exp(input string tag, input int first, input int nbits, input logic [11:0] val);
    exp_t e; e.tag = tag; e.first = first; e.nbits = nbits; e.val = val;
    sb.push_back(e);
  endtask

  initial forever begin
    @(frame_done);
    while (sb.size() > 0) begin
      exp_t e; logic [11:0] v;
      e = sb.pop_front(); v = '0;
      for (int i = 0; i < e.nbits; i++) v = {v[10:0], cap[e.first + i]};
      check(e.tag, v, e.val);
    end
    ->mon_done;
  end

  task automatic half_wait(); repeat (HALF) @(negedge clk); endtask

  task automatic frame(input logic [7:0] cmd, input logic [3:0] wb, input int nclk);
    for (int i = 0; i < 256; i++) cap[i] = 1'b0;
    csn = 0; half_wait();
    for (int n = 1; n <= nclk; n++) begin
      din = (n <= 8) ? cmd[8-n] : ((n <= 12) ? wb[12-n] : 1'b0);
      half_wait(); sclk = 1; half_wait(); sclk = 0; half_wait();
      cap[n] = dout;
    end
    csn = 1; din = 0; half_wait();
    ->frame_done; @(mon_done);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [3:0] v);
    frame({4'b1010, a, 1'b0}, v, 16);
  endtask

  task automatic rd_reg(input string tag, input logic [2:0] a, input logic [3:0] exp, input int first);
    push_exp(tag, first, 4, {8'h00, exp});
    frame({4'b1010, a, 1'b1}, 4'h0, 16);
  endtask

  initial begin
    int base;
    repeat (5) @(negedge clk); rst_n = 1; repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cfg", {cfg_panel, cfg_continue, cfg_count, cfg_ddly, cfg_seqm, cfg_interval, 1'b0}, 12'h0);
    check("R1 sleep/req", {cfg_sleep, conv_req, intclk_cmd}, 12'h0);
    check("R1 oe idle", {11'h0, dout_oe}, 12'h0);

    // R2 R3 12-bit single shot, chan 1, pd 1
    base = nreq;
    push_exp("R3 12b data", 9, 12, stub_val(base));
    push_exp("R3 tail zero", 21, 4, 12'h0);
    frame(8'b1001_0001, 4'h0, 24);
    check("R2 req count", 12'(nreq - base), 12'd1);
    check("R2 fields", {7'h0, last_chan, last_mode, last_pd}, {7'h0, 3'd1, 1'b0, 1'b1});

    // R4 8-bit, chan 5, pd 0
    base = nreq;
    push_exp("R4 8b data", 9, 8, {4'h0, stub_val(base)[11:4]});
    push_exp("R4 tail zero", 17, 8, 12'h0);
    frame(8'b1101_1000, 4'h0, 24);
    check("R4 fields", {7'h0, last_chan, last_mode, last_pd}, {7'h0, 3'd5, 1'b1, 1'b0});

    // R7 R8 early window, write/read reg 0
    wr_reg(3'd0, 4'b0001);
    check("R7 ddly port", {11'h0, cfg_ddly}, 12'h1);
    rd_reg("R8 read reg0", 3'd0, 4'b0001, 8);

    // R5 conversion with early window
    base = nreq;
    push_exp("R5 early data", 8, 12, stub_val(base));
    frame(8'b1110_0000, 4'h0, 24);
    check("R5 req count", 12'(nreq - base), 12'd1);

    // R6 continuous, 6 results
    wr_reg(3'd0, 4'b0100);
    base = nreq;
    for (int k = 0; k < 6; k++) push_exp("R6 run6 slot", 9 + 16*k, 12, stub_val(base + k));
    frame(8'b1011_0000, 4'h0, 105);
    check("R6 run6 count", 12'(nreq - base), 12'd6);

    // R6 continuous, 10 results
    wr_reg(3'd0, 4'b0110);
    base = nreq;
    for (int k = 0; k < 10; k++) push_exp("R6 run10 slot", 9 + 16*k, 12, stub_val(base + k));
    frame(8'b1001_0000, 4'h0, 169);
    check("R6 run10 count", 12'(nreq - base), 12'd10);
    wr_reg(3'd0, 4'b1000);
    check("R7 panel port", {8'h0, cfg_panel, cfg_continue, cfg_count, cfg_ddly}, 12'h8);

    // R7 masked registers
    wr_reg(3'd1, 4'b1011); rd_reg("R7 reg1", 3'd1, 4'b1010, 9);
    wr_reg(3'd2, 4'b0111); rd_reg("R7 reg2", 3'd2, 4'b0110, 9);
    seq_state = 2'b01;
    wr_reg(3'd3, 4'b1111); rd_reg("R7 reg3", 3'd3, 4'b1101, 9);
    check("R7 fields", {3'h0, cfg_seqm, cfg_interval, 1'b0, cfg_sleep}, {3'h0, 3'b101, 3'b011, 1'b0, 2'b11});

    // R11 reserved address
    wr_reg(3'd5, 4'b1111);
    rd_reg("R11 reserved read", 3'd5, 4'b0000, 9);
    rd_reg("R11 reg0 intact", 3'd0, 4'b1000, 9);

    // R9 no start bit
    base = nreq;
    push_exp("R9 dout quiet", 9, 12, 12'h0);
    frame(8'b0001_0000, 4'h0, 24);
    check("R9 no req", 12'(nreq - base), 12'd0);
    frame(8'b0010_0010, 4'b1111, 16);
    rd_reg("R9 reg1 intact", 3'd1, 4'b1010, 9);

    // R10 aborted write
    frame(8'b1010_0010, 4'b0100, 11);
    rd_reg("R10 reg1 intact", 3'd1, 4'b1010, 9);
    check("R10 oe idle", {11'h0, dout_oe}, 12'h0);

    // R12 internal clock command
    frame(8'b1010_1111, 4'h0, 8);
    check("R12 pulse", 12'(n_intclk), 12'd1);
    check("R12 dir", {11'h0, last_rd}, 12'h1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule